// File: doc/BRIEF.md
# Shifted-Offset Load Address Unit

This unit serves the load path of a 64-bit processor. For each load it forms an effective address: a base value plus a signed immediate that is first sign-extended and then shifted left by an amount read from a third register. It sends one memory read of 1, 2, 4 or 8 bytes and turns the returned bytes into a 64-bit result, either zero-extended or sign-extended. Update forms also return the effective address as the new base-register value.

There is an optional element mode for strided vector walks. In that mode the immediate is first multiplied by the bit-reversed element step, and the product is what gets shifted. The unit holds one load at a time. It takes a request on a valid/ready handshake, issues the memory read in the cycle after it accepts the request, waits for the memory response, and then pulses a result-valid strobe.

Top module: `sxl_load_unit`

## Requirements
- R1: The shift amount is `req_shift[5:0]` (0 to 63). Bits 63:6 of `req_shift` have no effect on the address.
- R2: `mem_req_addr` equals base + (sign-extended offset << shift amount), wrapped modulo 2^64.
- R3: In a non-update request (`req_update`=0) with `req_base_zero`=1, the base is zero and `req_base` has no effect.
- R4: In an update request, `req_base` is always the base. When the update is legal, the response carries `rsp_wb_valid`=1 and `rsp_wb_data` equal to the effective address.
- R5: With `req_ds_form`=1, the offset is `{req_imm[13:0],2'b00}` sign-extended from bit 15.
- R6: Size code 0 reads a byte, 1 a halfword, 2 a word and 3 a doubleword. The code is echoed on `mem_req_size`. The result is the low 1, 2, 4 or 8 bytes of `mem_rsp_data`. These are sign-extended when `req_signed`=1 and the size code is 1 or 2, and zero-extended otherwise. For byte and doubleword loads `req_signed` has no effect.
- R7: An update request with `req_base_zero`=1, or with `req_base_idx` equal to `req_dst_idx`, is illegal. It still performs the load, but its response shows `rsp_illegal`=1 and `rsp_wb_valid`=0.
- R8: `req_ready` is 1 only while the unit is idle. An accepted request raises `mem_req_valid` for exactly the one cycle after acceptance. Requests offered while a load is in flight are not taken.
- R9: `rsp_valid` pulses for one cycle, in the cycle after `mem_rsp_valid` is seen while the unit waits. A `mem_rsp_valid` in the issue cycle is ignored.
- R10: With `req_brev`=1, the offset is the sign-extended immediate multiplied by the low L bits of `req_step` written in reverse order, where L = `req_vlen_log2` (0 to 6). Step bits at L and above are ignored, and L=0 gives an offset of zero.
- R11: During reset, `req_ready`=1 and `mem_req_valid`, `rsp_valid`, `rsp_wb_valid` and `rsp_illegal` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Load request offered |
| req_ready | output | 1 | Unit can take a request |
| req_base | input | 64 | Base register contents |
| req_base_zero | input | 1 | Base register index is zero |
| req_base_idx | input | 5 | Base register index |
| req_dst_idx | input | 5 | Destination register index |
| req_imm | input | 16 | Signed immediate field |
| req_shift | input | 64 | Shift-control register contents |
| req_size | input | 2 | Access size code |
| req_signed | input | 1 | Sign-extend the result |
| req_update | input | 1 | Update form: write the address back to the base |
| req_ds_form | input | 1 | Doubleword immediate form: append two zero bits |
| req_brev | input | 1 | Element mode: scale by the bit-reversed step |
| req_step | input | 6 | Element step index |
| req_vlen_log2 | input | 3 | log2 of the vector length |
| mem_req_valid | output | 1 | Memory read strobe |
| mem_req_addr | output | 64 | Memory read address |
| mem_req_size | output | 2 | Memory read size code |
| mem_rsp_valid | input | 1 | Memory data returned |
| mem_rsp_data | input | 64 | Returned data, right-aligned |
| rsp_valid | output | 1 | Result strobe |
| rsp_data | output | 64 | Formatted load result |
| rsp_wb_valid | output | 1 | Base write-back is valid |
| rsp_wb_data | output | 64 | Base write-back value |
| rsp_illegal | output | 1 | Request was an illegal update form |

## Verification
The effective address is captured when the request is accepted. A fault in the address path therefore shows up on `mem_req_addr` in the very next cycle. A fault in the formatting path shows up on `rsp_data` in the cycle after the memory response. A corrupted state register shows at the ports as a missing or doubled `mem_req_valid`, as `req_ready` staying low, or as an `rsp_valid` with no memory response before it. Each of these is visible within one cycle of the step where it goes wrong. A wrong held legality flag shows only at the response, as `rsp_wb_valid` set together with `rsp_illegal`, or as a write-back that is missing.

// File: rtl/sxl_pkg.sv
package sxl_pkg;

   typedef enum logic [1:0] {
      SZ_B = 2'd0,
      SZ_H = 2'd1,
      SZ_W = 2'd2,
      SZ_D = 2'd3
   } sxl_size_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ISSUE = 2'd1,
      ST_WAIT  = 2'd2
   } sxl_state_e;

endpackage

// File: rtl/sxl_bitrev.sv
module sxl_bitrev #(
   parameter int STEP_W = 6,
   localparam int LEN_W = $clog2(STEP_W + 1)
) (
   input  logic [STEP_W-1:0] step,
   input  logic [LEN_W-1:0]  len,
   output logic [STEP_W-1:0] rev
);

   int len_c;

   always_comb begin
      len_c = (int'(len) > STEP_W) ? STEP_W : int'(len);
      rev   = '0;
      for (int i = 0; i < STEP_W; i++) begin
         if (i < len_c) rev[i] = step[len_c - 1 - i];
      end
   end

endmodule

// File: rtl/sxl_ea_calc.sv
module sxl_ea_calc #(
   parameter int XLEN    = 64,
   parameter int IMM_W   = 16,
   parameter int STEP_W  = 6,
   parameter bit BREV_EN = 1'b1,
   localparam int SH_W   = $clog2(XLEN),
   localparam int LEN_W  = $clog2(STEP_W + 1)
) (
   input  logic [XLEN-1:0]   base,
   input  logic              base_as_zero,
   input  logic [IMM_W-1:0]  imm,
   input  logic              ds_form,
   input  logic [SH_W-1:0]   shamt,
   input  logic              brev,
   input  logic [STEP_W-1:0] step,
   input  logic [LEN_W-1:0]  vlen_log2,
   output logic [XLEN-1:0]   ea
);

   logic [IMM_W-1:0] imm_x;
   logic [XLEN-1:0]  imm_sx;
   logic [XLEN-1:0]  offset;
   logic [XLEN-1:0]  base_eff;

   assign imm_x    = ds_form ? {imm[IMM_W-3:0], 2'b00} : imm;
   assign imm_sx   = {{(XLEN-IMM_W){imm_x[IMM_W-1]}}, imm_x};
   assign base_eff = base_as_zero ? '0 : base;

   generate
      if (BREV_EN) begin : g_brev
         logic [STEP_W-1:0] rev;
         logic [XLEN-1:0]   scaled;
         sxl_bitrev #(.STEP_W(STEP_W)) u_rev (
            .step (step),
            .len  (vlen_log2),
            .rev  (rev)
         );
         assign scaled = imm_sx * {{(XLEN-STEP_W){1'b0}}, rev};
         assign offset = brev ? scaled : imm_sx;
      end else begin : g_plain
         logic unused_brev;
         assign unused_brev = ^{brev, step, vlen_log2};
         assign offset = imm_sx;
      end
   endgenerate

   assign ea = base_eff + (offset << shamt);

endmodule

// File: rtl/sxl_fmt.sv
module sxl_fmt #(
   parameter int XLEN = 64
) (
   input  sxl_pkg::sxl_size_e size,
   input  logic               sgn,
   input  logic [XLEN-1:0]    raw,
   output logic [XLEN-1:0]    result
);
   import sxl_pkg::*;

   always_comb begin
      unique case (size)
         SZ_B:    result = {{(XLEN-8){1'b0}}, raw[7:0]};
         SZ_H:    result = {{(XLEN-16){sgn & raw[15]}}, raw[15:0]};
         SZ_W:    result = {{(XLEN-32){sgn & raw[31]}}, raw[31:0]};
         default: result = raw;
      endcase
   end

endmodule

// File: rtl/sxl_load_unit.sv
module sxl_load_unit
   import sxl_pkg::*;
#(
   parameter int XLEN    = 64,
   parameter int IMM_W   = 16,
   parameter int IDX_W   = 5,
   parameter int STEP_W  = 6,
   parameter bit BREV_EN = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          req_valid,
   output logic                          req_ready,
   input  logic [XLEN-1:0]               req_base,
   input  logic                          req_base_zero,
   input  logic [IDX_W-1:0]              req_base_idx,
   input  logic [IDX_W-1:0]              req_dst_idx,
   input  logic [IMM_W-1:0]              req_imm,
   input  logic [XLEN-1:0]               req_shift,
   input  logic [1:0]                    req_size,
   input  logic                          req_signed,
   input  logic                          req_update,
   input  logic                          req_ds_form,
   input  logic                          req_brev,
   input  logic [STEP_W-1:0]             req_step,
   input  logic [$clog2(STEP_W+1)-1:0]   req_vlen_log2,
   output logic                          mem_req_valid,
   output logic [XLEN-1:0]               mem_req_addr,
   output logic [1:0]                    mem_req_size,
   input  logic                          mem_rsp_valid,
   input  logic [XLEN-1:0]               mem_rsp_data,
   output logic                          rsp_valid,
   output logic [XLEN-1:0]               rsp_data,
   output logic                          rsp_wb_valid,
   output logic [XLEN-1:0]               rsp_wb_data,
   output logic                          rsp_illegal
);

   localparam int SH_W = $clog2(XLEN);

   generate
      if (XLEN != 64) begin : g_bad_xlen
         $error("sxl_load_unit: XLEN must be 64");
      end
      if (IMM_W < 3 || IMM_W > XLEN) begin : g_bad_imm
         $error("sxl_load_unit: IMM_W out of range");
      end
      if (STEP_W < 1 || STEP_W > SH_W) begin : g_bad_step
         $error("sxl_load_unit: STEP_W out of range");
      end
      if (IDX_W < 1) begin : g_bad_idx
         $error("sxl_load_unit: IDX_W must be positive");
      end
   endgenerate

   sxl_state_e     state;
   logic [XLEN-1:0] ea_c;
   logic [XLEN-1:0] ea_q;
   sxl_size_e      size_q;
   logic           sgn_q;
   logic           wb_ok_q;
   logic           ill_q;
   logic           accept;
   logic           fire;
   logic           upd_bad;
   logic [XLEN-1:0] fmt_data;
   logic           unused_shift_hi;

   assign unused_shift_hi = ^req_shift[XLEN-1:SH_W];

   assign req_ready     = (state == ST_IDLE);
   assign accept        = req_valid && req_ready;
   assign fire          = (state == ST_WAIT) && mem_rsp_valid;
   assign upd_bad       = req_base_zero || (req_base_idx == req_dst_idx);

   sxl_ea_calc #(
      .XLEN    (XLEN),
      .IMM_W   (IMM_W),
      .STEP_W  (STEP_W),
      .BREV_EN (BREV_EN)
   ) u_ea (
      .base         (req_base),
      .base_as_zero (req_base_zero && !req_update),
      .imm          (req_imm),
      .ds_form      (req_ds_form),
      .shamt        (req_shift[SH_W-1:0]),
      .brev         (req_brev),
      .step         (req_step),
      .vlen_log2    (req_vlen_log2),
      .ea           (ea_c)
   );

   sxl_fmt #(.XLEN(XLEN)) u_fmt (
      .size   (size_q),
      .sgn    (sgn_q),
      .raw    (mem_rsp_data),
      .result (fmt_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
      end else begin
         unique case (state)
            ST_IDLE:  if (req_valid) state <= ST_ISSUE;
            ST_ISSUE: state <= ST_WAIT;
            ST_WAIT:  if (mem_rsp_valid) state <= ST_IDLE;
            default:  state <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ea_q    <= '0;
         size_q  <= SZ_B;
         sgn_q   <= 1'b0;
         wb_ok_q <= 1'b0;
         ill_q   <= 1'b0;
      end else if (accept) begin
         ea_q    <= ea_c;
         size_q  <= sxl_size_e'(req_size);
         sgn_q   <= req_signed;
         wb_ok_q <= req_update && !upd_bad;
         ill_q   <= req_update && upd_bad;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid    <= 1'b0;
         rsp_data     <= '0;
         rsp_wb_valid <= 1'b0;
         rsp_wb_data  <= '0;
         rsp_illegal  <= 1'b0;
      end else begin
         rsp_valid    <= fire;
         rsp_wb_valid <= fire && wb_ok_q;
         rsp_illegal  <= fire && ill_q;
         if (fire) begin
            rsp_data    <= fmt_data;
            rsp_wb_data <= ea_q;
         end
      end
   end

   assign mem_req_valid = (state == ST_ISSUE);
   assign mem_req_addr  = ea_q;
   assign mem_req_size  = size_q;

   // R8
   req_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready |=> mem_req_valid);

   // R8
   issue_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |=> !mem_req_valid);

   // R8
   busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> !req_ready);

   // R9
   rsp_after_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(mem_rsp_valid));

   // R9
   rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   // R7
   wb_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_wb_valid |-> rsp_valid && !rsp_illegal);

endmodule

// File: tb/sxl_load_unit_tb.sv
`timescale 1ns/1ps
module sxl_load_unit_tb;

   typedef struct packed {
      logic [63:0] base;
      logic        bz;
      logic [15:0] imm;
      logic [63:0] sh;
      logic        ds;
      logic        br;
      logic [5:0]  step;
      logic [2:0]  vl;
      logic        upd;
      logic [1:0]  size;
      logic        sgn;
      logic [4:0]  bidx;
      logic [4:0]  didx;
      logic [63:0] mem;
   } vec_t;

   localparam int NVEC = 12;
   localparam vec_t VECS [NVEC] = '{
      '{64'h1000, 1'b0, 16'h0010, 64'h4, 1'b0, 1'b0, 6'd0, 3'd0, 1'b0, 2'd0, 1'b1, 5'd1, 5'd2, 64'h1234_5678_9ABC_DEFF},
      '{64'h8000_0000, 1'b0, 16'h8000, 64'hFFFF_FFFF_FFFF_FFC2, 1'b0, 1'b0, 6'd0, 3'd0, 1'b0, 2'd1, 1'b1, 5'd1, 5'd2, 64'h8001},
      '{64'hDEAD_BEEF, 1'b1, 16'h0100, 64'h0, 1'b0, 1'b0, 6'd0, 3'd0, 1'b0, 2'd2, 1'b0, 5'd0, 5'd2, 64'h8000_0000},
      '{64'h4000, 1'b0, 16'h0008, 64'h3, 1'b0, 1'b0, 6'd0, 3'd0, 1'b1, 2'd2, 1'b1, 5'd3, 5'd4, 64'hFFFF_FFFF_8000_0000},
      '{64'h100, 1'b0, 16'h3FFF, 64'h1, 1'b1, 1'b0, 6'd0, 3'd0, 1'b0, 2'd3, 1'b0, 5'd1, 5'd2, 64'h0123_4567_89AB_CDEF},
      '{64'h2000, 1'b1, 16'h0004, 64'h0, 1'b0, 1'b0, 6'd0, 3'd0, 1'b1, 2'd1, 1'b0, 5'd0, 5'd4, 64'hFFFF_FFFF_FFFF_8001},
      '{64'h3000, 1'b0, 16'h0004, 64'h0, 1'b0, 1'b0, 6'd0, 3'd0, 1'b1, 2'd0, 1'b0, 5'd7, 5'd7, 64'hAB},
      '{64'h0, 1'b0, 16'h0003, 64'h2, 1'b0, 1'b1, 6'd1, 3'd3, 1'b0, 2'd1, 1'b0, 5'd1, 5'd2, 64'h7FFF},
      '{64'h500, 1'b0, 16'hFFFE, 64'h0, 1'b0, 1'b1, 6'b110110, 3'd2, 1'b0, 2'd2, 1'b1, 5'd1, 5'd2, 64'h7FFF_FFFF},
      '{64'h0, 1'b0, 16'h0001, 64'h0, 1'b0, 1'b1, 6'd1, 3'd6, 1'b0, 2'd3, 1'b0, 5'd1, 5'd2, 64'h55},
      '{64'h700, 1'b0, 16'h0005, 64'h0, 1'b0, 1'b1, 6'd3, 3'd0, 1'b0, 2'd0, 1'b0, 5'd1, 5'd2, 64'h1},
      '{64'h0, 1'b0, 16'h0001, 64'h3F, 1'b0, 1'b0, 6'd0, 3'd0, 1'b0, 2'd3, 1'b1, 5'd1, 5'd2, 64'h8000_0000_0000_0000}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [63:0] req_base = '0;
   logic        req_base_zero = 1'b0;
   logic [4:0]  req_base_idx = '0;
   logic [4:0]  req_dst_idx = '0;
   logic [15:0] req_imm = '0;
   logic [63:0] req_shift = '0;
   logic [1:0]  req_size = '0;
   logic        req_signed = 1'b0;
   logic        req_update = 1'b0;
   logic        req_ds_form = 1'b0;
   logic        req_brev = 1'b0;
   logic [5:0]  req_step = '0;
   logic [2:0]  req_vlen_log2 = '0;
   logic        mem_req_valid;
   logic [63:0] mem_req_addr;
   logic [1:0]  mem_req_size;
   logic        mem_rsp_valid = 1'b0;
   logic [63:0] mem_rsp_data = '0;
   logic        rsp_valid;
   logic [63:0] rsp_data;
   logic        rsp_wb_valid;
   logic [63:0] rsp_wb_data;
   logic        rsp_illegal;

   int checks = 0;
   int errors = 0;
   logic [63:0] last_addr;

   always #4 clk = ~clk;

   sxl_load_unit u_dut (
      .clk, .rst_n, .req_valid, .req_ready, .req_base, .req_base_zero,
      .req_base_idx, .req_dst_idx, .req_imm, .req_shift, .req_size,
      .req_signed, .req_update, .req_ds_form, .req_brev, .req_step,
      .req_vlen_log2, .mem_req_valid, .mem_req_addr, .mem_req_size,
      .mem_rsp_valid, .mem_rsp_data, .rsp_valid, .rsp_data,
      .rsp_wb_valid, .rsp_wb_data, .rsp_illegal
   );

   task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", rq, act, exp);
      end
   endtask

   function automatic string vtag(input int i);
      case (i)
         0: return "R2 plain, R6 byte signed ignored";
         1: return "R1 shift high bits, R6 half signed";
         2: return "R3 zero base";
         3: return "R4 update, R6 word signed";
         4: return "R5 ds form";
         5: return "R7 update with zero index";
         6: return "R7 update same index";
         7: return "R10 reversed step";
         8: return "R10 high step bits ignored";
         9: return "R10 full length";
         10: return "R10 zero length";
         default: return "R1 shift 63, R6 dword signed ignored";
      endcase
   endfunction

   function automatic logic [63:0] exp_ea(input vec_t v);
      logic [15:0] ix;
      logic [63:0] s;
      logic [63:0] r;
      logic [63:0] b;
      ix = v.ds ? {v.imm[13:0], 2'b00} : v.imm;
      s  = {{48{ix[15]}}, ix};
      r  = '0;
      if (v.br) begin
         for (int i = 0; i < int'(v.vl); i++) r[int'(v.vl) - 1 - i] = v.step[i];
         s = s * r;
      end
      b = (v.bz && !v.upd) ? 64'h0 : v.base;
      return b + (s << v.sh[5:0]);
   endfunction

   function automatic logic [63:0] exp_data(input vec_t v);
      case (v.size)
         2'd0: return {56'h0, v.mem[7:0]};
         2'd1: return {{48{v.sgn & v.mem[15]}}, v.mem[15:0]};
         2'd2: return {{32{v.sgn & v.mem[31]}}, v.mem[31:0]};
         default: return v.mem;
      endcase
   endfunction

   task automatic run_vec(input vec_t v, input string tag, input bit junk, input int stall);
      logic wb_e;
      wb_e = v.upd && !v.bz && (v.bidx != v.didx);
      @(negedge clk);
      req_base = v.base; req_base_zero = v.bz; req_imm = v.imm; req_shift = v.sh;
      req_ds_form = v.ds; req_brev = v.br; req_step = v.step; req_vlen_log2 = v.vl;
      req_update = v.upd; req_size = v.size; req_signed = v.sgn;
      req_base_idx = v.bidx; req_dst_idx = v.didx; req_valid = 1'b1;
      chk("R8 ready when idle", {63'h0, req_ready}, 64'h1);
      @(negedge clk);
      req_valid = 1'b0;
      chk("R8 issue after accept", {63'h0, mem_req_valid}, 64'h1);
      chk("R8 not ready in flight", {63'h0, req_ready}, 64'h0);
      chk({tag, " address"}, mem_req_addr, exp_ea(v));
      chk("R6 size echo", {62'h0, mem_req_size}, {62'h0, v.size});
      last_addr = mem_req_addr;
      if (junk) begin
         mem_rsp_valid = 1'b1;
         mem_rsp_data = ~v.mem;
      end
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      chk("R8 single issue cycle", {63'h0, mem_req_valid}, 64'h0);
      chk("R9 no early result", {63'h0, rsp_valid}, 64'h0);
      for (int s = 0; s < stall; s++) begin
         req_valid = 1'b1;
         req_base = ~v.base;
         @(negedge clk);
         chk("R9 no result while waiting", {63'h0, rsp_valid}, 64'h0);
         chk("R8 busy refuses request", {63'h0, req_ready}, 64'h0);
      end
      req_valid = 1'b0;
      mem_rsp_valid = 1'b1;
      mem_rsp_data = v.mem;
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      chk("R9 result strobe", {63'h0, rsp_valid}, 64'h1);
      chk({tag, " R6 data"}, rsp_data, exp_data(v));
      chk({tag, " R4 R7 wb valid"}, {63'h0, rsp_wb_valid}, {63'h0, wb_e});
      chk({tag, " R7 illegal"}, {63'h0, rsp_illegal}, {63'h0, v.upd && !wb_e});
      if (wb_e) chk({tag, " R4 wb data"}, rsp_wb_data, exp_ea(v));
      @(negedge clk);
      chk("R9 strobe one cycle", {63'h0, rsp_valid}, 64'h0);
      chk("R8 no stray issue", {63'h0, mem_req_valid}, 64'h0);
   endtask

   initial begin
      #(8 * 100000);
      errors++;
      $display("FAIL R8 watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      // R11 reset state
      repeat (2) @(negedge clk);
      chk("R11 ready in reset", {63'h0, req_ready}, 64'h1);
      chk("R11 mem idle in reset", {63'h0, mem_req_valid}, 64'h0);
      chk("R11 rsp idle in reset", {63'h0, rsp_valid}, 64'h0);
      chk("R11 wb idle in reset", {63'h0, rsp_wb_valid}, 64'h0);
      chk("R11 illegal clear in reset", {63'h0, rsp_illegal}, 64'h0);
      rst_n = 1'b1;

      for (int i = 0; i < NVEC; i++) begin
         run_vec(VECS[i], vtag(i), 1'b0, 0);
         if (i == 0) chk("R2 literal 0x1000+(0x10<<4)", last_addr, 64'h1100);
         if (i == 7) chk("R10 literal rev(1,3)*3<<2", last_addr, 64'h30);
         if (i == 11) chk("R1 literal 1<<63", last_addr, 64'h8000_0000_0000_0000);
      end

      // R9 stray memory response in issue cycle, R8 requests refused while waiting
      run_vec(VECS[3], "R9 junk and stall", 1'b1, 3);
      run_vec(VECS[1], "R9 junk only", 1'b1, 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule